// File: doc/BRIEF.md
# Chained Wide Divide-Remainder Unit

This unit divides an unsigned 128-bit dividend by an unsigned 64-bit divisor and returns the 64-bit quotient and the 64-bit remainder of that one division. The dividend is the concatenation of a high word and a low word, and the divisor is taken as zero-extended. A restoring, one-bit-per-step core does the work. Because a valid divide always has a high word below the divisor, only the low word's bits need to be stepped through, so a normal divide takes one cycle per low-word bit.

The unit can also divide a big integer made of several limbs by a single-limb divisor. Software issues the limbs from the most significant down. The first limb is started with a high word of zero. Each later limb is started with the chain input set, and the unit then uses its own previous remainder as the high word. The quotient limbs arrive in order, and the last remainder is the remainder of the whole number.

When the quotient cannot fit in 64 bits, the unit reports overflow and forces the quotient to all ones. A zero divisor is reported separately as divide-by-zero.

Top module: `chain_divider`

## Requirements
- R1: With a nonzero divisor and a high word (`hi_i`, or the held remainder when `chain_i` is 1) below the divisor, the unit returns quotient = floor({high,lo_i}/divisor) and remainder = {high,lo_i} mod divisor. The remainder is below the divisor, and `ovf_o` and `dz_o` are both 0.
- R2: With a nonzero divisor and a high word greater than or equal to the divisor, the unit raises `ovf_o`=1 with `dz_o`=0. It sets the quotient to all ones and the remainder to `lo_i`. `done_o` rises at the edge that accepts `start_i`.
- R3: With a zero divisor, the unit raises both `dz_o`=1 and `ovf_o`=1. It sets the quotient to all ones and the remainder to `lo_i`. `done_o` rises at the edge that accepts `start_i`.
- R4: When `chain_i`=1 at the accepting edge, the high word is the remainder currently shown on `rem_o`, and `hi_i` has no effect.
- R5: A divide without overflow raises `busy_o` from the accepting edge for W/SPC cycles. At the W/SPC-th edge after acceptance, `busy_o` falls and `done_o` rises together with the results. `busy_o` and `done_o` are never both high.
- R6: `start_i` is ignored while `busy_o` is 1. The result in progress, and its timing, are unchanged.
- R7: `done_o` is high for exactly one cycle per accepted start. Quotient, remainder and flags change only in that cycle and are held until the next result.
- R8: Synchronous active-high reset clears `busy_o`, `done_o`, `quot_o`, `rem_o`, `ovf_o` and `dz_o` to 0.
- R9: A multi-limb dividend divided limb by limb is never flagged as overflow for a nonzero divisor. This holds when the first limb uses a high word of 0 and later limbs use `chain_i`=1. The quotient limbs and final remainder equal those of the full-width division.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a divide; accepted only when idle |
| chain_i | input | 1 | Use the held remainder as the high word |
| hi_i | input | W | High word of the dividend |
| lo_i | input | W | Low word of the dividend |
| divisor_i | input | W | Divisor |
| busy_o | output | 1 | Divide in progress |
| done_o | output | 1 | One-cycle result strobe |
| quot_o | output | W | Quotient |
| rem_o | output | W | Remainder |
| ovf_o | output | 1 | Quotient did not fit |
| dz_o | output | 1 | Divisor was zero |

## Verification
Single divides are run with small operands, with a divisor of one, and with an all-ones divisor under the largest legal high word. They are also run with a power-of-two divisor and with random words. Together these separate a wrong restore or subtract decision, a dropped or misordered quotient bit, and an off-by-one step count.

Three cases probe the flag logic: a high word equal to the divisor, a high word above it, and a zero divisor. These check the boundary of the overflow compare and show whether divide-by-zero is kept apart from plain overflow.

A four-limb chain, fed with a junk high word, shows whether the remainder really loops back and whether the fed-in high word is ignored. A start pulse issued mid-divide shows whether a busy unit lets itself be disturbed.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_t;

    typedef struct packed {
        logic zero_div;
        logic too_big;
    } guard_t;

    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/div_guard.sv
module div_guard #(
    parameter int W = 64
) (
    input  logic [W-1:0]   hi_i,
    input  logic [W-1:0]   div_i,
    output div_pkg::guard_t res_o
);
    // A high word at or above the divisor means the quotient needs more than W bits.
    // A zero divisor always satisfies that compare, so it reports overflow as well.
    always_comb begin
        res_o.zero_div = (div_i == '0);
        res_o.too_big  = (hi_i >= div_i);
    end
endmodule

// File: rtl/div_bit_step.sv
module div_bit_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] div_i,
    output logic [W-1:0] rem_o,
    output logic         q_o
);
    logic [W:0] partial;
    logic [W:0] diff;

    always_comb begin
        partial = {rem_i, bit_i};
        diff    = partial - {1'b0, div_i};
        q_o     = (partial >= {1'b0, div_i});
        rem_o   = q_o ? diff[W-1:0] : partial[W-1:0];
    end
endmodule

// File: rtl/div_step_chain.sv
module div_step_chain #(
    parameter int W   = 64,
    parameter int SPC = 1
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] div_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W-1:0] rem_s [SPC+1];
    logic [W-1:0] quo_s [SPC+1];

    assign rem_s[0] = rem_i;
    assign quo_s[0] = quo_i;

    // Each stage pulls the top dividend bit out of the shift word
    // and pushes the new quotient bit in at the bottom.
    for (genvar i = 0; i < SPC; i++) begin : g_stage
        logic qb;
        div_bit_step #(.W(W)) u_bit (
            .rem_i (rem_s[i]),
            .bit_i (quo_s[i][W-1]),
            .div_i (div_i),
            .rem_o (rem_s[i+1]),
            .q_o   (qb)
        );
        assign quo_s[i+1] = {quo_s[i][W-2:0], qb};
    end

    assign rem_o = rem_s[SPC];
    assign quo_o = quo_s[SPC];
endmodule

// File: rtl/chain_divider.sv
module chain_divider
    import div_pkg::*;
#(
    parameter int W   = 64,
    parameter int SPC = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         chain_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic [W-1:0] rem_o,
    output logic         ovf_o,
    output logic         dz_o
);
    localparam int ITER = W / SPC;
    localparam int CW   = cnt_width(ITER);
    localparam logic [CW-1:0] LAST = CW'(ITER - 1);

    state_t       st;
    logic [CW-1:0] cnt;
    logic [W-1:0] prem, pquo, pdiv;
    logic [W-1:0] rem_n, quo_n;
    logic [W-1:0] hi_sel;
    guard_t       g;
    logic         accept, last;

    // The chain input loops the held remainder back as the high word.
    assign hi_sel = chain_i ? rem_o : hi_i;

    div_guard #(.W(W)) u_guard (
        .hi_i  (hi_sel),
        .div_i (divisor_i),
        .res_o (g)
    );

    div_step_chain #(.W(W), .SPC(SPC)) u_steps (
        .rem_i (prem),
        .quo_i (pquo),
        .div_i (pdiv),
        .rem_o (rem_n),
        .quo_o (quo_n)
    );

    assign accept = (st == ST_IDLE) && start_i;
    assign last   = (st == ST_RUN) && (cnt == LAST);
    assign busy_o = (st == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            prem   <= '0;
            pquo   <= '0;
            pdiv   <= '0;
            done_o <= 1'b0;
            quot_o <= '0;
            rem_o  <= '0;
            ovf_o  <= 1'b0;
            dz_o   <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (accept) begin
                if (g.too_big) begin
                    // Overflow or zero divisor: settle at once.
                    done_o <= 1'b1;
                    quot_o <= '1;
                    rem_o  <= lo_i;
                    ovf_o  <= 1'b1;
                    dz_o   <= g.zero_div;
                end else begin
                    // High word is already below the divisor, so it is the
                    // starting partial remainder; only the low word is stepped.
                    st   <= ST_RUN;
                    cnt  <= '0;
                    prem <= hi_sel;
                    pquo <= lo_i;
                    pdiv <= divisor_i;
                end
            end else if (st == ST_RUN) begin
                prem <= rem_n;
                pquo <= quo_n;
                cnt  <= cnt + 1'b1;
                if (last) begin
                    st     <= ST_IDLE;
                    done_o <= 1'b1;
                    quot_o <= quo_n;
                    rem_o  <= rem_n;
                    ovf_o  <= 1'b0;
                    dz_o   <= 1'b0;
                end
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);                                            // R7
    AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> ($stable(quot_o) && $stable(rem_o) && $stable(ovf_o) && $stable(dz_o))); // R7
    AST_OVF_ONES: assert property (@(posedge clk) disable iff (rst)
        (done_o && ovf_o) |-> (quot_o == '1));                          // R2
    AST_DZ_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (done_o && dz_o) |-> ovf_o);                                    // R3
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (rst)
        (done_o && !ovf_o) |-> (rem_o < pdiv));                         // R1
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !last) |=> (busy_o && $stable(pdiv)));               // R6
    AST_BUSY_DONE: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));                                           // R5
endmodule

// File: tb/chain_divider_bench.sv
module chain_divider_bench;
    localparam int W = 64;
    localparam int LAT = 64;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         chain_i = 1'b0;
    logic [W-1:0] hi_i = '0, lo_i = '0, divisor_i = '0;
    logic         busy_o, done_o, ovf_o, dz_o;
    logic [W-1:0] quot_o, rem_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    chain_divider u_chain_divider (
        .clk(clk), .rst(rst), .start_i(start_i), .chain_i(chain_i),
        .hi_i(hi_i), .lo_i(lo_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o), .rem_o(rem_o),
        .ovf_o(ovf_o), .dz_o(dz_o)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    logic         m_busy = 0, m_done = 0, m_ovf = 0, m_dz = 0;
    logic [W-1:0] m_q = '0, m_r = '0, p_q = '0, p_r = '0;
    int           m_cnt = 0;

    always @(posedge clk) begin
        logic [W-1:0]   h;
        logic [2*W-1:0] num, q2, r2;
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_ovf <= 0; m_dz <= 0;
            m_q <= '0; m_r <= '0; m_cnt <= 0;
        end else begin
            m_done <= 0;
            if (!m_busy && start_i) begin
                h = chain_i ? m_r : hi_i;
                if (divisor_i == 0) begin
                    m_done <= 1; m_ovf <= 1; m_dz <= 1; m_q <= '1; m_r <= lo_i;
                end else if (h >= divisor_i) begin
                    m_done <= 1; m_ovf <= 1; m_dz <= 0; m_q <= '1; m_r <= lo_i;
                end else begin
                    num = {h, lo_i};
                    q2 = num / {{W{1'b0}}, divisor_i};
                    r2 = num % {{W{1'b0}}, divisor_i};
                    p_q <= q2[W-1:0];
                    p_r <= r2[W-1:0];
                    m_busy <= 1;
                    m_cnt <= LAT;
                end
            end else if (m_busy) begin
                m_cnt <= m_cnt - 1;
                if (m_cnt == 1) begin
                    m_busy <= 0; m_done <= 1; m_q <= p_q; m_r <= p_r;
                    m_ovf <= 0; m_dz <= 0;
                end
            end
        end
    end

    // Per-cycle comparison, away from the rising edge.
    always @(negedge clk) begin
        if (!rst && !ended) begin
            chk("R5 busy", W'(busy_o), W'(m_busy));
            chk("R7 done", W'(done_o), W'(m_done));
            if (m_dz) begin
                chk("R3 quotient", quot_o, m_q);
                chk("R3 remainder", rem_o, m_r);
            end else if (m_ovf) begin
                chk("R2 quotient", quot_o, m_q);
                chk("R2 remainder", rem_o, m_r);
            end else begin
                chk("R1 quotient", quot_o, m_q);
                chk("R1 remainder", rem_o, m_r);
            end
            chk("R2 ovf flag", W'(ovf_o), W'(m_ovf));
            chk("R3 dz flag", W'(dz_o), W'(m_dz));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            finish_run();
        end
    end

    logic [W-1:0] r_q, r_r;
    logic         r_ovf, r_dz;

    task automatic run_op(input logic ch, input logic [W-1:0] hi, input logic [W-1:0] lo,
                          input logic [W-1:0] dv);
        @(negedge clk);
        chain_i = ch; hi_i = hi; lo_i = lo; divisor_i = dv; start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int k = 0; k < 200 && !done_o; k++) @(negedge clk);
        r_q = quot_o; r_r = rem_o; r_ovf = ovf_o; r_dz = dz_o;
    endtask

    task automatic single(input logic [W-1:0] hi, input logic [W-1:0] lo, input logic [W-1:0] dv);
        logic [2*W-1:0] num, q2, r2;
        run_op(1'b0, hi, lo, dv);
        if (dv == 0) begin
            chk("R3 dz", W'(r_dz), 1); chk("R3 ovf", W'(r_ovf), 1);
            chk("R3 quot ones", r_q, '1); chk("R3 rem=lo", r_r, lo);
        end else if (hi >= dv) begin
            chk("R2 ovf", W'(r_ovf), 1); chk("R2 dz", W'(r_dz), 0);
            chk("R2 quot ones", r_q, '1); chk("R2 rem=lo", r_r, lo);
        end else begin
            num = {hi, lo};
            q2 = num / {{W{1'b0}}, dv};
            r2 = num % {{W{1'b0}}, dv};
            chk("R1 quot", r_q, q2[W-1:0]); chk("R1 rem", r_r, r2[W-1:0]);
            chk("R1 ovf clear", W'(r_ovf), 0);
        end
    endtask

    initial begin
        logic [4*W-1:0] big, bq, br;
        logic [W-1:0]   d, a_hi, a_lo, a_dv;
        logic [2*W-1:0] num;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 busy", W'(busy_o), 0); chk("R8 done", W'(done_o), 0);
        chk("R8 quot", quot_o, 0); chk("R8 rem", rem_o, 0);
        chk("R8 ovf", W'(ovf_o), 0); chk("R8 dz", W'(dz_o), 0);
        rst = 0;

        single(64'd0, 64'd100, 64'd7);
        single(64'd0, 64'h0123_4567_89ab_cdef, 64'd1);
        single(64'hffff_ffff_ffff_fffe, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff);
        single(64'h0000_0000_0000_ffff, 64'h8000_0000_0000_0001, 64'h0000_0000_0001_0000);
        for (int i = 0; i < 6; i++) begin
            d = {$urandom, $urandom} | 64'h1;
            single({$urandom, $urandom} % d, {$urandom, $urandom}, d);
        end
        single(64'd5, 64'd9, 64'd5);                    // R2 boundary: hi == divisor
        single(64'hffff_0000_0000_0000, 64'd3, 64'd12); // R2: hi above divisor
        single(64'd4, 64'hdead_beef, 64'd0);            // R3

        // R6: start pulse mid-divide is ignored
        a_hi = 64'd3; a_lo = 64'h1357_9bdf_0246_8ace; a_dv = 64'd1000;
        @(negedge clk);
        chain_i = 0; hi_i = a_hi; lo_i = a_lo; divisor_i = a_dv; start_i = 1;
        @(negedge clk);
        start_i = 0;
        repeat (10) @(negedge clk);
        hi_i = 0; lo_i = 64'd77; divisor_i = 64'd2; start_i = 1;
        @(negedge clk);
        start_i = 0;
        for (int k = 0; k < 200 && !done_o; k++) @(negedge clk);
        num = {a_hi, a_lo};
        chk("R6 quot unaffected", quot_o, W'(num / {{W{1'b0}}, a_dv}));
        chk("R6 rem unaffected", rem_o, W'(num % {{W{1'b0}}, a_dv}));
        @(negedge clk);
        chk("R7 done one cycle", W'(done_o), 0);

        // R9 / R4: four-limb dividend by one-limb divisor
        big = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
        d = {$urandom, $urandom} | 64'h8000_0000_0000_0001;
        bq = big / {{(3*W){1'b0}}, d};
        br = big % {{(3*W){1'b0}}, d};
        for (int j = 3; j >= 0; j--) begin
            if (j == 3) run_op(1'b0, '0, big[W*j +: W], d);
            else        run_op(1'b1, 64'hbad0_bad0_bad0_bad0, big[W*j +: W], d);
            chk("R9 limb quotient", r_q, bq[W*j +: W]);
            chk("R9 no overflow", W'(r_ovf), 0);
        end
        chk("R4 chained remainder", r_r, br[W-1:0]);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule